// File: doc/BRIEF.md
# NAND Sector BCH Parity Engine

This block computes BCH parity for NAND flash data while the data streams past on an 8-bit or 16-bit bus. Each 512-byte sector is divided, as a binary polynomial, by the generator of a binary BCH code over GF(2^13). The generator corrects either 4 or 8 bit errors per sector. The remainder of that division is the sector's parity. One remainder bank is kept for each sector, up to eight sectors per pass. Software reads the banks back as 32-bit result words.

Software first programs a configuration word. It then writes the control word to clear the banks and arm the engine. Data arrives as valid/ready beats tagged with a chip-select number. A beat transfers on a rising clock edge where both `s_valid` and `s_ready` are high. While `s_ready` is low the source must hold its beat; nothing is consumed. `s_ready` is high only while the engine is armed and enabled and the programmed sectors are not yet complete. A beat whose chip-select differs from the programmed one is accepted and then discarded. The result words are a combinational view of the banks, so a partial remainder can be read at any time.

Top module: `bch_nand_parity`

## Requirements
- R1: After reset every result word reads 0, `s_ready` is low and `all_done` is low.
- R2: With bit 12 of the configuration word clear (t=4), the bank of a sector holds the 52-bit remainder of m(x)·x^52 divided by g(x). Here m(x) is the sector's data, taken byte by byte with each byte most significant bit first. g(x) is the product of the minimal polynomials of alpha^1, alpha^3, alpha^5 and alpha^7 in GF(2^13), with field polynomial x^13+x^4+x^3+x+1 (0x201B).
- R3: With bit 12 set (t=8), the bank holds the 104-bit remainder of m(x)·x^104. The generator for this mode is built from alpha^1 through alpha^15 (odd powers only).
- R4: For t=4, the result words of a sector are as follows. Word 0 holds remainder bits 31:0. Word 1 holds remainder bits 51:32 in its bits 19:0, with its bits 31:20 zero. Words 2 and 3 read zero.
- R5: For t=8, words 0, 1 and 2 hold remainder bits 31:0, 63:32 and 95:64. Word 3 holds bits 103:96 in its low 8 bits, with its upper bits zero.
- R6: With bit 7 of the configuration word set (16-bit bus), each beat carries two bytes. `s_data[7:0]` enters the division before `s_data[15:8]`. With bit 7 clear, only `s_data[7:0]` is used.
- R7: After 512 bytes the next sector's bank receives data. Bits 6:4 hold the number of sectors minus one. When the last programmed sector completes, `all_done` rises on the same edge.
- R8: Data is taken only while bit 0 (ECC enable) and bit 16 (BCH enable) are both set. A transferred beat whose `s_cs` differs from bits 3:1 changes no bank and no sector count.
- R9: `s_ready` is high exactly when the engine is armed, both enables are set and `all_done` is low. While `s_ready` is low, a held beat changes nothing.
- R10: A control write with bit 8 set clears all banks, the sector count and `all_done`. Every control write loads bit 0 as the armed flag, so a write without bit 0 stops intake and keeps the banks.
- R11: The result words keep their values while no data is transferred and no clear is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word (bit 8 clear, bit 0 arm) |
| s_valid | input | 1 | Data beat valid |
| s_ready | output | 1 | Engine takes the beat |
| s_data | input | 16 | Data beat, low byte first in 16-bit mode |
| s_cs | input | 3 | Chip-select of the beat |
| rd_sector | input | 3 | Sector bank to read |
| rd_word | input | 2 | Result word index within the bank |
| rd_data | output | 32 | Selected result word |
| all_done | output | 1 | All programmed sectors complete |

## Verification
A beat taken at a rising edge updates its sector's bank at that same edge. Because the result words are combinational, the new remainder is readable straight after that edge. `all_done`, `s_ready` and the sector count also change at that edge. Configuration and control writes take effect at the edge that captures them. The bench therefore drives inputs just after a rising edge and runs its reference model on the rising edge. At each falling edge it compares the model with `s_ready`, `all_done` and all 32 result words, stepping the read selectors within that half period.

// File: rtl/bch_nand_pkg.sv
`timescale 1ns/100ps
package bch_nand_pkg;
  localparam int GF_M = 13;
  localparam logic [GF_M:0] GF_POLY = 14'h201B;
  localparam int T_LO = 4;
  localparam int T_HI = 8;
  localparam int PAR_MAX = GF_M * T_HI;
  localparam int MAX_SECT = 8;

  typedef struct packed {
    logic       ecc_en;
    logic [2:0] cs;
    logic [2:0] nsect_m1;
    logic       wide;
    logic       t8;
    logic       bch_en;
  } bch_cfg_t;

  // multiply in GF(2^13), shift-and-add with modular reduction
  function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a, input logic [GF_M-1:0] b);
    logic [GF_M-1:0] p;
    p = '0;
    for (int i = GF_M - 1; i >= 0; i--) begin
      p = {p[GF_M-2:0], 1'b0} ^ (p[GF_M-1] ? GF_POLY[GF_M-1:0] : '0);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  // generator = product of (x + r) over every conjugate of alpha^1..alpha^(2t-1), odd powers
  function automatic logic [PAR_MAX:0] gen_poly(input int t);
    logic [GF_M-1:0] c [PAR_MAX+1];
    logic [GF_M-1:0] a, r;
    logic [PAR_MAX:0] g;
    int deg;
    for (int j = 0; j <= PAR_MAX; j++) c[j] = '0;
    c[0] = 1;
    deg = 0;
    for (int i = 1; i < 2 * t; i += 2) begin
      a = 1;
      for (int n = 0; n < i; n++) a = gf_mul(a, 13'd2);
      r = a;
      for (int k = 0; k < GF_M; k++) begin
        for (int j = PAR_MAX; j >= 1; j--)
          if (j <= deg + 1) c[j] = c[j-1] ^ gf_mul(c[j], r);
        c[0] = gf_mul(c[0], r);
        deg++;
        r = gf_mul(r, r);
      end
    end
    for (int j = 0; j <= PAR_MAX; j++) g[j] = c[j][0];
    return g;
  endfunction
endpackage

// File: rtl/bch_lfsr_step.sv
`timescale 1ns/100ps
module bch_lfsr_step
  import bch_nand_pkg::*;
#(
  parameter int T = 4
) (
  input  logic [GF_M*T-1:0] rem_i,
  input  logic [15:0]       data_i,
  input  logic              wide_i,
  output logic [GF_M*T-1:0] rem_o
);
  localparam int DEG = GF_M * T;
  localparam logic [PAR_MAX:0] GFULL = gen_poly(T);
  localparam logic [DEG-1:0] GTAP = GFULL[DEG-1:0];

  // up to 16 serial division steps per beat: low byte first, MSB first within a byte
  always_comb begin
    logic [DEG-1:0] r;
    logic [3:0] idx;
    logic fb;
    r = rem_i;
    for (int i = 0; i < 16; i++) begin
      idx = (i < 8) ? 4'(7 - i) : 4'(23 - i);
      if (i < 8 || wide_i) begin
        fb = data_i[idx] ^ r[DEG-1];
        r = {r[DEG-2:0], 1'b0} ^ (fb ? GTAP : '0);
      end
    end
    rem_o = r;
  end
endmodule

// File: rtl/bch_sector_ctrl.sv
`timescale 1ns/100ps
module bch_sector_ctrl #(
  parameter int SECT_BYTES = 512,
  parameter int MAX_SECT   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_i,
  input  logic                        beat_i,
  input  logic                        wide_i,
  input  logic [$clog2(MAX_SECT)-1:0] last_i,
  output logic [$clog2(MAX_SECT)-1:0] sect_o,
  output logic                        done_o
);
  localparam int CW = $clog2(SECT_BYTES) + 1;
  localparam int SW = $clog2(MAX_SECT);

  logic [CW-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + (wide_i ? CW'(2) : CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sect_o <= '0;
      done_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      sect_o <= '0;
      done_o <= 1'b0;
    end else if (beat_i) begin
      if (cnt_nxt >= CW'(SECT_BYTES)) begin
        cnt_q <= '0;
        if (sect_o == last_i) done_o <= 1'b1;
        else sect_o <= sect_o + SW'(1);
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  // R7
  sect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_i && !clr_i) |=> ($stable(sect_o) && $stable(done_o)));
endmodule

// File: rtl/bch_cfg_regs.sv
`timescale 1ns/100ps
module bch_cfg_regs
  import bch_nand_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  output bch_cfg_t    cfg_o,
  output logic        armed_o,
  output logic        clr_o
);
  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[31:17], cfg_wdata[15:13], cfg_wdata[11:8],
                         ctrl_wdata[31:9], ctrl_wdata[7:1]};

  assign clr_o = ctrl_we && ctrl_wdata[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o   <= '0;
      armed_o <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_o.ecc_en   <= cfg_wdata[0];
        cfg_o.cs       <= cfg_wdata[3:1];
        cfg_o.nsect_m1 <= cfg_wdata[6:4];
        cfg_o.wide     <= cfg_wdata[7];
        cfg_o.t8       <= cfg_wdata[12];
        cfg_o.bch_en   <= cfg_wdata[16];
      end
      if (ctrl_we) armed_o <= ctrl_wdata[0];
    end
  end

  // R10
  arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (armed_o == $past(ctrl_wdata[0])));
endmodule

// File: rtl/bch_nand_parity.sv
`timescale 1ns/100ps
module bch_nand_parity
  import bch_nand_pkg::*;
#(
  parameter int SECT_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [15:0] s_data,
  input  logic [2:0]  s_cs,
  input  logic [2:0]  rd_sector,
  input  logic [1:0]  rd_word,
  output logic [31:0] rd_data,
  output logic        all_done
);
  localparam int SW = $clog2(MAX_SECT);
  localparam int P4 = GF_M * T_LO;
  localparam int P8 = GF_M * T_HI;

  bch_cfg_t cfg;
  logic armed, clr, fire, hit;
  logic [SW-1:0] sect;
  logic [P8-1:0] bank [MAX_SECT];
  logic [P8-1:0] cur, rsel;
  logic [P4-1:0] nxt4;
  logic [P8-1:0] nxt8;

  bch_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cfg_o(cfg), .armed_o(armed), .clr_o(clr)
  );

  assign s_ready = armed && cfg.ecc_en && cfg.bch_en && !all_done;
  assign fire    = s_valid && s_ready;
  assign hit     = fire && (s_cs == cfg.cs);

  bch_sector_ctrl #(.SECT_BYTES(SECT_BYTES), .MAX_SECT(MAX_SECT)) u_sect (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .beat_i(hit), .wide_i(cfg.wide),
    .last_i(cfg.nsect_m1[SW-1:0]), .sect_o(sect), .done_o(all_done)
  );

  assign cur = bank[sect];

  bch_lfsr_step #(.T(T_LO)) u_step4 (
    .rem_i(cur[P4-1:0]), .data_i(s_data), .wide_i(cfg.wide), .rem_o(nxt4)
  );
  bch_lfsr_step #(.T(T_HI)) u_step8 (
    .rem_i(cur), .data_i(s_data), .wide_i(cfg.wide), .rem_o(nxt8)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_SECT; i++) bank[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < MAX_SECT; i++) bank[i] <= '0;
    end else if (hit) begin
      bank[sect] <= cfg.t8 ? nxt8 : {{(P8-P4){1'b0}}, nxt4};
    end
  end

  // result word packing, selected by the current mode
  assign rsel = bank[rd_sector];
  always_comb begin
    rd_data = '0;
    if (cfg.t8) begin
      case (rd_word)
        2'd0: rd_data = rsel[31:0];
        2'd1: rd_data = rsel[63:32];
        2'd2: rd_data = rsel[95:64];
        default: rd_data = {24'b0, rsel[103:96]};
      endcase
    end else begin
      case (rd_word)
        2'd0: rd_data = rsel[31:0];
        2'd1: rd_data = {12'b0, rsel[51:32]};
        default: rd_data = '0;
      endcase
    end
  end

  // R9
  no_intake_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> !s_ready);
  // R10
  clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!all_done && sect == '0));
  // R8
  foreign_cs_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && s_cs != cfg.cs && !clr) |=> ($stable(sect) && $stable(all_done)));
endmodule

// File: tb/sim_bch_nand_parity.sv
`timescale 1ns/100ps
module sim_bch_nand_parity;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic [2:0]  s_cs = '0;
  logic [2:0]  rd_sector = '0;
  logic [1:0]  rd_word = '0;
  wire         s_ready;
  wire [31:0]  rd_data;
  wire         all_done;

  bch_nand_parity u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .s_cs(s_cs), .rd_sector(rd_sector),
    .rd_word(rd_word), .rd_data(rd_data), .all_done(all_done)
  );

  always #5 clk = ~clk;

  int vecs = 0;
  int fails = 0;
  bit finished = 0;
  bit started = 0;
  string cur_tag = "R1";

  // GF(2^13) tables for the independent generator construction
  int gexp [0:8191];
  int glog [0:8191];
  logic [104:0] gp4, gp8;

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 8191];
  endfunction

  function automatic logic [104:0] bgen(int t);
    int c [0:104];
    int d;
    logic [104:0] g;
    for (int j = 0; j <= 104; j++) c[j] = 0;
    c[0] = 1;
    d = 0;
    for (int i = 1; i < 2 * t; i += 2) begin
      for (int k = 0; k < 13; k++) begin
        int e;
        int root;
        e = (i * (1 << k)) % 8191;
        root = gexp[e];
        for (int j = d + 1; j >= 1; j--) c[j] = c[j-1] ^ gmul(c[j], root);
        c[0] = gmul(c[0], root);
        d++;
      end
    end
    for (int j = 0; j <= 104; j++) g[j] = c[j][0];
    return g;
  endfunction

  // reference model state
  bit m_ecc = 0, m_bch = 0, m_wide = 0, m_t8 = 0, m_armed = 0, m_done = 0;
  int m_cs = 0, m_nm1 = 0, m_sect = 0, m_bytes = 0;
  logic [103:0] m_rem [8];

  function automatic bit ref_ready();
    return m_armed && m_ecc && m_bch && !m_done;
  endfunction

  task automatic model_byte(input logic [7:0] b);
    int dg;
    logic [103:0] mask, g;
    dg = m_t8 ? 104 : 52;
    mask = (104'd1 << dg) - 104'd1;
    if (dg == 104) mask = '1;
    g = (m_t8 ? gp8[103:0] : gp4[103:0]) & mask;
    for (int k = 7; k >= 0; k--) begin
      bit fb;
      fb = b[k] ^ m_rem[m_sect][dg-1];
      m_rem[m_sect] = (m_rem[m_sect] << 1) & mask;
      if (fb) m_rem[m_sect] = m_rem[m_sect] ^ g;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ecc = 0; m_bch = 0; m_wide = 0; m_t8 = 0; m_armed = 0; m_done = 0;
      m_cs = 0; m_nm1 = 0; m_sect = 0; m_bytes = 0;
      for (int s = 0; s < 8; s++) m_rem[s] = '0;
    end else begin
      if (s_valid && ref_ready() && int'(s_cs) == m_cs) begin
        model_byte(s_data[7:0]);
        if (m_wide) model_byte(s_data[15:8]);
        m_bytes += m_wide ? 2 : 1;
        if (m_bytes >= 512) begin
          m_bytes = 0;
          if (m_sect == m_nm1) m_done = 1;
          else m_sect++;
        end
      end
      if (cfg_we) begin
        m_ecc = cfg_wdata[0]; m_cs = int'(cfg_wdata[3:1]); m_nm1 = int'(cfg_wdata[6:4]);
        m_wide = cfg_wdata[7]; m_t8 = cfg_wdata[12]; m_bch = cfg_wdata[16];
      end
      if (ctrl_we) begin
        if (ctrl_wdata[8]) begin
          for (int s = 0; s < 8; s++) m_rem[s] = '0;
          m_sect = 0; m_bytes = 0; m_done = 0;
        end
        m_armed = ctrl_wdata[0];
      end
    end
  end

  function automatic logic [31:0] exp_word(int s, int w);
    logic [103:0] r;
    r = m_rem[s];
    if (m_t8) begin
      case (w)
        0: return r[31:0];
        1: return r[63:32];
        2: return r[95:64];
        default: return {24'b0, r[103:96]};
      endcase
    end
    case (w)
      0: return r[31:0];
      1: return {12'b0, r[51:32]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  // compare everything on each falling edge
  always @(negedge clk) begin
    if (started && !finished) begin
      chk(s_ready == ref_ready(), "R9", {31'b0, s_ready}, {31'b0, ref_ready()});
      chk(all_done == m_done, "R7", {31'b0, all_done}, {31'b0, m_done});
      for (int s = 0; s < 8; s++) begin
        for (int w = 0; w < 4; w++) begin
          logic [31:0] e;
          rd_sector = 3'(s);
          rd_word = 2'(w);
          #0.1;
          e = exp_word(s, w);
          chk(rd_data === e, cur_tag, rd_data, e);
        end
      end
    end
  end

  function automatic int unsigned nx(int unsigned x);
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic write_cfg(input bit t8, input bit wide, input logic [2:0] nm1,
                           input logic [2:0] cs, input bit ecc, input bit bch);
    cfg_wdata = {15'b0, bch, 3'b0, t8, 4'h6, wide, nm1, cs, ecc};
    cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic write_ctrl(input logic [31:0] v);
    ctrl_wdata = v;
    ctrl_we = 1'b1;
    @(posedge clk); #1;
    ctrl_we = 1'b0;
  endtask

  task automatic send(input logic [15:0] d, input logic [2:0] cs);
    bit acc;
    s_valid = 1'b1;
    s_data = d;
    s_cs = cs;
    forever begin
      @(negedge clk);
      acc = s_ready;
      @(posedge clk);
      if (acc) break;
    end
    #1;
    s_valid = 1'b0;
  endtask

  task automatic hold_valid(input int n);
    s_valid = 1'b1;
    s_data = 16'hA55A;
    repeat (n) @(posedge clk);
    #1;
    s_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d cycles expected completion", 150000);
    finish_run();
  end

  initial begin
    int unsigned rs;
    int x;
    x = 1;
    for (int i = 0; i < 8191; i++) begin
      gexp[i] = x;
      glog[x] = i;
      x = x << 1;
      if (x & 8192) x = x ^ 32'h201B;
    end
    gp4 = bgen(4);
    gp8 = bgen(8);
    for (int s = 0; s < 8; s++) m_rem[s] = '0;
    rs = 32'h1234_5678;

    cur_tag = "R1";
    started = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;

    // not yet armed: held data must not be taken (R9)
    cur_tag = "R9";
    write_cfg(0, 0, 3'd0, 3'd2, 1, 1);
    hold_valid(3);
    write_ctrl(32'h101);

    // t=4, all-0xFF sector (R2 R4)
    cur_tag = "R2 R4";
    for (int i = 0; i < 512; i++) send(16'h00FF, 3'd2);
    cur_tag = "R11";
    repeat (5) @(posedge clk);
    #1;
    cur_tag = "R9";
    hold_valid(4);

    // t=8, three sectors of varied data with bubbles and foreign beats (R3 R5 R8)
    write_cfg(1, 0, 3'd2, 3'd5, 1, 1);
    write_ctrl(32'h101);
    for (int i = 0; i < 3 * 512; i++) begin
      rs = nx(rs);
      if (i % 37 == 5) begin
        cur_tag = "R8";
        send(16'(rs), 3'd1);
      end
      cur_tag = "R3 R5";
      if (i % 50 == 7) begin
        @(posedge clk); #1;
      end
      send(16'(rs >> 8), 3'd5);
    end
    cur_tag = "R11";
    repeat (4) @(posedge clk);
    #1;

    // t=8, 16-bit bus, two sectors (R6)
    cur_tag = "R6";
    write_cfg(1, 1, 3'd1, 3'd0, 1, 1);
    write_ctrl(32'h101);
    for (int i = 0; i < 2 * 256; i++) begin
      rs = nx(rs);
      send(16'(rs), 3'd0);
    end

    // t=4, 16-bit bus, all eight sectors, with a pause by disarming (R7 R10)
    write_cfg(0, 1, 3'd7, 3'd3, 1, 1);
    write_ctrl(32'h101);
    for (int i = 0; i < 8 * 256; i++) begin
      rs = nx(rs);
      cur_tag = "R7";
      if (i == 100) begin
        cur_tag = "R10";
        write_ctrl(32'h000);
        hold_valid(3);
        write_ctrl(32'h001);
      end
      send(16'(rs ^ (rs >> 16)), 3'd3);
    end

    // enables gate intake (R8)
    cur_tag = "R8";
    write_cfg(0, 0, 3'd0, 3'd4, 0, 1);
    write_ctrl(32'h101);
    hold_valid(3);
    write_cfg(0, 0, 3'd0, 3'd4, 1, 0);
    hold_valid(3);
    write_cfg(0, 0, 3'd0, 3'd4, 1, 1);
    for (int i = 0; i < 10; i++) begin
      rs = nx(rs);
      send(16'(rs), 3'd4);
    end

    // clear in the middle of a sector (R10)
    cur_tag = "R10";
    write_ctrl(32'h101);
    for (int i = 0; i < 6; i++) send(16'h003C, 3'd4);
    repeat (3) @(posedge clk);
    #1;
    finish_run();
  end
endmodule